// File: doc/BRIEF.md
# Inset Window and Border Generator

This block sits on the display side of a picture-in-picture path. It counts pixels and lines of the parent raster from the parent sync pulses. It compares the count against a programmed inset position and against the inset size that the decimation and line-standard codes imply. From that comparison it issues read requests to the inset field store. The pixels that come back are merged with a programmable border colour, and the result goes out as three 6-bit component values.

Alongside the pixels the block drives a fast-switch select line for an external video switch. The select line covers both the picture and its border, and it can be moved earlier or later than the pixel stream by a signed number of pixel clocks. An optional mode reads every stored line twice, for parent rasters that run at twice the line rate.

Top module: `pip_window_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `mem_rd_en_o`, `sel_o` and all three pixel outputs are 0.
- R2: Column count restarts at 0 on the clock edge that samples `hsync_i` high and rises by one per enabled clock. Line count restarts at 0 on the edge that samples `vsync_i` high and rises by one on each other `hsync_i` edge. The picture occupies columns from 54 + `pos_h_i` and lines from 4 + `pos_v_i`. Everything that is neither picture nor border outputs 0 on all three components.
- R3: Picture width is 212 columns when `hdec4_i` = 0 and 160 when it is 1. Stored line count by {`vdec4_i`,`std525_i`} is 00 → 88, 01 → 76, 10 → 66, 11 → 57.
- R4: The border is the set of points that are not picture and that lie within `brd_wh_i` columns (0–7) left or right of the picture and within `brd_wv_i` lines (0–3) above or below it, corners included. A width of 0 adds no border on that axis. Each border component is its 4-bit colour input in bits 5:2, with bits 1:0 zero.
- R5: For a picture point at column offset c and stored line l, `mem_rd_en_o` is high one clock after the counters reach it, with `mem_rd_pix_o` = c and `mem_rd_line_o` = l. The memory returns data one clock after the request. A point reached by the counters after enabled clock j appears on the pixel outputs after enabled clock j+12.
- R6: With `line_dbl_i` = 1 the picture is twice as tall, and stored line l is read on picture lines 2l and 2l+1.
- R7: Position inputs take effect only at the `vsync_i` edge. A change made mid-field does not move the current picture.
- R8: With `pip_on_i` = 0 there are no memory reads, no picture or border, and `sel_o` stays 0.
- R9: `sel_o` is high for picture and border points. `sel_dly_i` is a two's-complement value d from −8 to +7, and `sel_o` at output clock t equals the insertion state of output clock t−d. With d = 0 it is aligned with the pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Clock enable for all raster logic |
| hsync_i | input | 1 | Parent line-start pulse |
| vsync_i | input | 1 | Parent field-start pulse |
| pip_on_i | input | 1 | Insertion enable |
| line_dbl_i | input | 1 | Read each stored line twice |
| hdec4_i | input | 1 | Horizontal size code (0: 212, 1: 160 columns) |
| vdec4_i | input | 1 | Vertical size code |
| std525_i | input | 1 | Inset line-standard code |
| pos_h_i | input | 10 | Horizontal position, pixels |
| pos_v_i | input | 8 | Vertical position, lines |
| brd_wh_i | input | 3 | Border width, columns |
| brd_wv_i | input | 2 | Border height, lines |
| brd_y_i | input | 4 | Border luma colour |
| brd_u_i | input | 4 | Border blue-difference colour |
| brd_v_i | input | 4 | Border red-difference colour |
| sel_dly_i | input | 4 | Signed select delay |
| mem_y_i | input | 6 | Stored luma returned by memory |
| mem_u_i | input | 6 | Stored blue-difference returned by memory |
| mem_v_i | input | 6 | Stored red-difference returned by memory |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_rd_line_o | output | 7 | Stored line index |
| mem_rd_pix_o | output | 8 | Stored column index |
| pix_y_o | output | 6 | Output luma |
| pix_u_o | output | 6 | Output blue-difference |
| pix_v_o | output | 6 | Output red-difference |
| sel_o | output | 1 | Fast-switch select |

## Verification
The hardest case to reach is the select line at the ends of its delay range while line doubling stretches the picture and the border lines follow the doubled end. In that case the select edges fall up to eight clocks away from the pixel edges, and a whole field has to run before the bottom border appears. The stimulus uses 300-clock lines and cuts each field short two lines after its lowest border line. This lets six full configurations fit: both extreme delays, doubling, every size code, zero and maximum border widths, a mid-field position change and a disabled field. Every clock is compared against a pipeline-aligned history of expected points.

// File: rtl/pip_win_pkg.sv
package pip_win_pkg;

  localparam int COLI_W = 8;   // stored column index width
  localparam int LINE_W = 7;   // stored line index width

  typedef struct packed {
    logic pic;
    logic brd;
  } area_t;

  function automatic logic [COLI_W-1:0] inset_cols(input logic hdec4);
    return hdec4 ? COLI_W'(160) : COLI_W'(212);
  endfunction

  function automatic logic [LINE_W-1:0] inset_lines(input logic vdec4, input logic std525);
    case ({vdec4, std525})
      2'b00:   return LINE_W'(88);
      2'b01:   return LINE_W'(76);
      2'b10:   return LINE_W'(66);
      default: return LINE_W'(57);
    endcase
  endfunction

endpackage

// File: rtl/pip_raster_cnt.sv
module pip_raster_cnt #(
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 10,
  parameter int POSH_W = 10,
  parameter int POSV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [POSH_W-1:0] pos_h_i,
  input  logic [POSV_W-1:0] pos_v_i,
  output logic [HCNT_W-1:0] hcnt_o,
  output logic [VCNT_W-1:0] vcnt_o,
  output logic [POSH_W-1:0] pos_h_o,
  output logic [POSV_W-1:0] pos_v_o
);

  localparam logic [HCNT_W-1:0] HMAX = '1;
  localparam logic [VCNT_W-1:0] VMAX = '1;

  logic [HCNT_W-1:0] hcnt_q;
  logic [VCNT_W-1:0] vcnt_q;
  logic [POSH_W-1:0] pos_h_q;
  logic [POSV_W-1:0] pos_v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      pos_h_q <= '0;
      pos_v_q <= '0;
    end else if (pix_en_i) begin
      if (hsync_i)             hcnt_q <= '0;
      else if (hcnt_q != HMAX) hcnt_q <= hcnt_q + 1'b1;

      if (vsync_i)                        vcnt_q <= '0;
      else if (hsync_i && vcnt_q != VMAX) vcnt_q <= vcnt_q + 1'b1;

      if (vsync_i) begin
        pos_h_q <= pos_h_i;
        pos_v_q <= pos_v_i;
      end
    end
  end

  assign hcnt_o  = hcnt_q;
  assign vcnt_o  = vcnt_q;
  assign pos_h_o = pos_h_q;
  assign pos_v_o = pos_v_q;

  AST_HCNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (pix_en_i && hsync_i) |=> (hcnt_q == '0)); // R2

  AST_POS_HOLD_MIDFIELD: assert property (@(posedge clk) disable iff (rst)
    !(pix_en_i && vsync_i) |=> ($stable(pos_h_q) && $stable(pos_v_q))); // R7

endmodule

// File: rtl/pip_area_cmp.sv
module pip_area_cmp
  import pip_win_pkg::*;
#(
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 10,
  parameter int POSH_W = 10,
  parameter int POSV_W = 8,
  parameter int BWH_W  = 3,
  parameter int BWV_W  = 2,
  parameter int H_ORG  = 54,
  parameter int V_ORG  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en_i,
  input  logic              en_i,
  input  logic              dbl_i,
  input  logic              hdec4_i,
  input  logic              vdec4_i,
  input  logic              std525_i,
  input  logic [HCNT_W-1:0] hcnt_i,
  input  logic [VCNT_W-1:0] vcnt_i,
  input  logic [POSH_W-1:0] pos_h_i,
  input  logic [POSV_W-1:0] pos_v_i,
  input  logic [BWH_W-1:0]  bwh_i,
  input  logic [BWV_W-1:0]  bwv_i,
  output area_t             area_o,
  output logic              rd_en_o,
  output logic [LINE_W-1:0] rd_line_o,
  output logic [COLI_W-1:0] rd_col_o
);

  localparam int HW = HCNT_W + 1;
  localparam int VW = VCNT_W + 1;

  logic [HW-1:0]     h_ext, h_beg, h_end, h_lo, h_hi;
  logic [VW-1:0]     v_ext, v_beg, v_end, v_lo, v_hi, v_rel;
  logic [LINE_W-1:0] n_lines;
  logic [LINE_W:0]   v_tall;
  logic              in_ph, in_pv, in_oh, in_ov, pic_d, brd_d;
  logic [LINE_W-1:0] line_d;
  logic [COLI_W-1:0] col_d;

  always_comb begin
    h_ext   = HW'(hcnt_i);
    h_beg   = HW'(H_ORG) + HW'(pos_h_i);
    h_end   = h_beg + HW'(inset_cols(hdec4_i));
    h_lo    = h_ext + HW'(bwh_i);
    h_hi    = h_end + HW'(bwh_i);

    n_lines = inset_lines(vdec4_i, std525_i);
    v_tall  = dbl_i ? {n_lines, 1'b0} : {1'b0, n_lines};
    v_ext   = VW'(vcnt_i);
    v_beg   = VW'(V_ORG) + VW'(pos_v_i);
    v_end   = v_beg + VW'(v_tall);
    v_lo    = v_ext + VW'(bwv_i);
    v_hi    = v_end + VW'(bwv_i);

    in_ph   = (h_ext >= h_beg) && (h_ext < h_end);
    in_pv   = (v_ext >= v_beg) && (v_ext < v_end);
    in_oh   = (h_lo  >= h_beg) && (h_ext < h_hi);
    in_ov   = (v_lo  >= v_beg) && (v_ext < v_hi);

    pic_d   = en_i && in_ph && in_pv;
    brd_d   = en_i && in_oh && in_ov && !pic_d;

    v_rel   = v_ext - v_beg;
    line_d  = dbl_i ? LINE_W'(v_rel >> 1) : LINE_W'(v_rel);
    col_d   = COLI_W'(h_ext - h_beg);
  end

  area_t             area_q;
  logic              rd_en_q;
  logic [LINE_W-1:0] rd_line_q;
  logic [COLI_W-1:0] rd_col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      area_q    <= '0;
      rd_en_q   <= 1'b0;
      rd_line_q <= '0;
      rd_col_q  <= '0;
    end else if (pix_en_i) begin
      area_q.pic <= pic_d;
      area_q.brd <= brd_d;
      rd_en_q    <= pic_d;
      if (pic_d) begin
        rd_line_q <= line_d;
        rd_col_q  <= col_d;
      end
    end else begin
      rd_en_q <= 1'b0;
    end
  end

  assign area_o    = area_q;
  assign rd_en_o   = rd_en_q;
  assign rd_line_o = rd_line_q;
  assign rd_col_o  = rd_col_q;

  AST_DISABLED_NO_READ: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !rd_en_q); // R8

  AST_BORDER_NEEDS_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (area_q.brd && $past(pix_en_i)) |-> ($past(bwh_i) != '0 || $past(bwv_i) != '0)); // R4

endmodule

// File: rtl/pip_out_stage.sv
module pip_out_stage
  import pip_win_pkg::*;
#(
  parameter int PIX_W = 6,
  parameter int COL_W = 4,
  parameter int DLY_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pix_en_i,
  input  area_t                area_i,
  input  logic [3*PIX_W-1:0]   mem_i,
  input  logic [3*COL_W-1:0]   brd_col_i,
  input  logic [DLY_W-1:0]     sel_dly_i,
  output logic [3*PIX_W-1:0]   pix_o,
  output logic                 sel_o
);

  localparam int DW   = 3 * PIX_W;
  localparam int HALF = 2 ** (DLY_W - 1);
  localparam int TAPS = 2 ** DLY_W;
  localparam int FILL = PIX_W - COL_W;

  area_t          s2_q;
  logic [DW-1:0]  px_d;
  logic           ins_d;

  always_ff @(posedge clk) begin
    if (rst)           s2_q <= '0;
    else if (pix_en_i) s2_q <= area_i;
  end

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    logic [PIX_W-1:0] brd_px;
    if (FILL > 0) begin : g_fill
      assign brd_px = {brd_col_i[ch*COL_W +: COL_W], {FILL{1'b0}}};
    end else begin : g_nofill
      assign brd_px = brd_col_i[ch*COL_W +: PIX_W];
    end
    assign px_d[ch*PIX_W +: PIX_W] = s2_q.pic ? mem_i[ch*PIX_W +: PIX_W] :
                                     s2_q.brd ? brd_px : '0;
  end

  assign ins_d = s2_q.pic | s2_q.brd;

  logic [HALF:0][DW-1:0] dl_q;
  logic [TAPS-1:0]       fl_q;
  logic [DLY_W-1:0]      tap;
  logic [DW-1:0]         pix_q;
  logic                  act_q, sel_q;

  assign tap = sel_dly_i + DLY_W'(HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      dl_q  <= '0;
      fl_q  <= '0;
      pix_q <= '0;
      act_q <= 1'b0;
      sel_q <= 1'b0;
    end else if (pix_en_i) begin
      dl_q  <= {dl_q[HALF-1:0], px_d};
      fl_q  <= {fl_q[TAPS-2:0], ins_d};
      pix_q <= dl_q[HALF];
      act_q <= fl_q[HALF];
      sel_q <= fl_q[tap];
    end
  end

  assign pix_o = pix_q;
  assign sel_o = sel_q;

  AST_BLANK_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> (pix_q == '0)); // R2

endmodule

// File: rtl/pip_window_gen.sv
module pip_window_gen
  import pip_win_pkg::*;
#(
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 10,
  parameter int POSH_W = 10,
  parameter int POSV_W = 8,
  parameter int BWH_W  = 3,
  parameter int BWV_W  = 2,
  parameter int PIX_W  = 6,
  parameter int COL_W  = 4,
  parameter int DLY_W  = 4,
  parameter int H_ORG  = 54,
  parameter int V_ORG  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              pip_on_i,
  input  logic              line_dbl_i,
  input  logic              hdec4_i,
  input  logic              vdec4_i,
  input  logic              std525_i,
  input  logic [POSH_W-1:0] pos_h_i,
  input  logic [POSV_W-1:0] pos_v_i,
  input  logic [BWH_W-1:0]  brd_wh_i,
  input  logic [BWV_W-1:0]  brd_wv_i,
  input  logic [COL_W-1:0]  brd_y_i,
  input  logic [COL_W-1:0]  brd_u_i,
  input  logic [COL_W-1:0]  brd_v_i,
  input  logic [DLY_W-1:0]  sel_dly_i,
  input  logic [PIX_W-1:0]  mem_y_i,
  input  logic [PIX_W-1:0]  mem_u_i,
  input  logic [PIX_W-1:0]  mem_v_i,
  output logic              mem_rd_en_o,
  output logic [LINE_W-1:0] mem_rd_line_o,
  output logic [COLI_W-1:0] mem_rd_pix_o,
  output logic [PIX_W-1:0]  pix_y_o,
  output logic [PIX_W-1:0]  pix_u_o,
  output logic [PIX_W-1:0]  pix_v_o,
  output logic              sel_o
);

  logic [HCNT_W-1:0]  hcnt;
  logic [VCNT_W-1:0]  vcnt;
  logic [POSH_W-1:0]  pos_h_act;
  logic [POSV_W-1:0]  pos_v_act;
  area_t              area;
  logic [3*PIX_W-1:0] px;

  pip_raster_cnt #(
    .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .POSH_W(POSH_W), .POSV_W(POSV_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .pix_en_i(pix_en),
    .hsync_i(hsync_i), .vsync_i(vsync_i),
    .pos_h_i(pos_h_i), .pos_v_i(pos_v_i),
    .hcnt_o(hcnt), .vcnt_o(vcnt),
    .pos_h_o(pos_h_act), .pos_v_o(pos_v_act)
  );

  pip_area_cmp #(
    .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .POSH_W(POSH_W), .POSV_W(POSV_W),
    .BWH_W(BWH_W), .BWV_W(BWV_W), .H_ORG(H_ORG), .V_ORG(V_ORG)
  ) u_cmp (
    .clk(clk), .rst(rst), .pix_en_i(pix_en),
    .en_i(pip_on_i), .dbl_i(line_dbl_i),
    .hdec4_i(hdec4_i), .vdec4_i(vdec4_i), .std525_i(std525_i),
    .hcnt_i(hcnt), .vcnt_i(vcnt),
    .pos_h_i(pos_h_act), .pos_v_i(pos_v_act),
    .bwh_i(brd_wh_i), .bwv_i(brd_wv_i),
    .area_o(area), .rd_en_o(mem_rd_en_o),
    .rd_line_o(mem_rd_line_o), .rd_col_o(mem_rd_pix_o)
  );

  pip_out_stage #(
    .PIX_W(PIX_W), .COL_W(COL_W), .DLY_W(DLY_W)
  ) u_out (
    .clk(clk), .rst(rst), .pix_en_i(pix_en),
    .area_i(area),
    .mem_i({mem_y_i, mem_u_i, mem_v_i}),
    .brd_col_i({brd_y_i, brd_u_i, brd_v_i}),
    .sel_dly_i(sel_dly_i),
    .pix_o(px), .sel_o(sel_o)
  );

  assign pix_y_o = px[3*PIX_W-1:2*PIX_W];
  assign pix_u_o = px[2*PIX_W-1:PIX_W];
  assign pix_v_o = px[PIX_W-1:0];

endmodule

// File: tb/pip_window_gen_bench.sv
module pip_window_gen_bench;

  localparam int LINE  = 300;
  localparam int HD    = 20;
  localparam int WDOG  = 190000;
  localparam int NVEC  = 6;

  typedef struct packed {
    logic [9:0] ph;
    logic [7:0] pv;
    logic [9:0] alt;
    logic       hd, vd, sd, db, en;
    logic [2:0] bh;
    logic [1:0] bw;
    logic [3:0] dly;
    logic [3:0] cy, cu, cv;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{10'd2,  8'd0, 10'd0,  1'b0,1'b1,1'b1,1'b0,1'b1, 3'd3, 2'd2, 4'h0, 4'hA,4'h5,4'h3},
    '{10'd20, 8'd5, 10'd99, 1'b1,1'b0,1'b0,1'b0,1'b1, 3'd0, 2'd0, 4'h0, 4'hF,4'hF,4'hF},
    '{10'd10, 8'd3, 10'd0,  1'b0,1'b1,1'b0,1'b0,1'b1, 3'd7, 2'd3, 4'h8, 4'h4,4'hC,4'h8},
    '{10'd30, 8'd2, 10'd0,  1'b1,1'b1,1'b1,1'b1,1'b1, 3'd2, 2'd1, 4'h7, 4'h1,4'h2,4'hE},
    '{10'd24, 8'd1, 10'd0,  1'b0,1'b0,1'b1,1'b0,1'b1, 3'd0, 2'd3, 4'h3, 4'h9,4'h0,4'h6},
    '{10'd5,  8'd0, 10'd0,  1'b0,1'b1,1'b1,1'b0,1'b0, 3'd3, 2'd3, 4'h0, 4'hF,4'hF,4'hF}
  };
  localparam string TAGS [NVEC] = '{"R2", "R3 R7", "R4", "R6", "R9", "R8"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_i = 1'b0, vsync_i = 1'b0;
  logic pip_on_i, line_dbl_i, hdec4_i, vdec4_i, std525_i;
  logic [9:0] pos_h_i;
  logic [7:0] pos_v_i;
  logic [2:0] brd_wh_i;
  logic [1:0] brd_wv_i;
  logic [3:0] brd_y_i, brd_u_i, brd_v_i, sel_dly_i;
  logic [5:0] mem_y_i = '0, mem_u_i = '0, mem_v_i = '0;
  logic       mem_rd_en_o, sel_o;
  logic [6:0] mem_rd_line_o;
  logic [7:0] mem_rd_pix_o;
  logic [5:0] pix_y_o, pix_u_o, pix_v_o;

  always #5 clk = ~clk;

  pip_window_gen u_pip_window_gen (
    .clk(clk), .rst(rst), .pix_en(1'b1),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .pip_on_i(pip_on_i),
    .line_dbl_i(line_dbl_i), .hdec4_i(hdec4_i), .vdec4_i(vdec4_i), .std525_i(std525_i),
    .pos_h_i(pos_h_i), .pos_v_i(pos_v_i), .brd_wh_i(brd_wh_i), .brd_wv_i(brd_wv_i),
    .brd_y_i(brd_y_i), .brd_u_i(brd_u_i), .brd_v_i(brd_v_i), .sel_dly_i(sel_dly_i),
    .mem_y_i(mem_y_i), .mem_u_i(mem_u_i), .mem_v_i(mem_v_i),
    .mem_rd_en_o(mem_rd_en_o), .mem_rd_line_o(mem_rd_line_o), .mem_rd_pix_o(mem_rd_pix_o),
    .pix_y_o(pix_y_o), .pix_u_o(pix_u_o), .pix_v_o(pix_v_o), .sel_o(sel_o)
  );

  // Stored picture content: a function of stored line and column (R5)
  function automatic logic [17:0] store_val(input int l, input int c);
    logic [5:0] y, u, v;
    y = 6'((l * 3 + c) & 63);
    u = 6'((l + 2 * c) & 63);
    v = 6'((l ^ c) & 63);
    return {y, u, v};
  endfunction

  always @(posedge clk)
    if (mem_rd_en_o) {mem_y_i, mem_u_i, mem_v_i} <= store_val(int'(mem_rd_line_o), int'(mem_rd_pix_o));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string vtag = "R1";

  // Bench view of the raster, following the counting rules of R2 and R7
  int m_h = 0, m_v = 0, s_ph = 0, s_pv = 0;
  logic [17:0] hpx  [HD];
  logic        hins [HD];
  logic        hpic [HD];
  logic        hbrd [HD];
  int          hl   [HD];
  int          hc   [HD];
  int          nvalid = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", req, vtag, what, act, exp);
    end
  endtask

  task automatic tick(input logic h, input logic v);
    int w, nl, ht, hb, vb, bh, bw;
    logic pic, brd;
    logic [17:0] px;
    int ln, cl, d;
    w  = hdec4_i ? 160 : 212;
    case ({vdec4_i, std525_i})
      2'b00: nl = 88;  2'b01: nl = 76;  2'b10: nl = 66;  default: nl = 57;
    endcase
    ht = line_dbl_i ? 2 * nl : nl;
    hb = 54 + s_ph;  vb = 4 + s_pv;
    bh = int'(brd_wh_i);  bw = int'(brd_wv_i);
    pic = pip_on_i && m_h >= hb && m_h < hb + w && m_v >= vb && m_v < vb + ht;
    brd = pip_on_i && !pic && m_h + bh >= hb && m_h < hb + w + bh &&
          m_v + bw >= vb && m_v < vb + ht + bw;
    ln = line_dbl_i ? (m_v - vb) / 2 : (m_v - vb);
    cl = m_h - hb;
    px = pic ? store_val(ln, cl) :
         brd ? {brd_y_i, 2'b00, brd_u_i, 2'b00, brd_v_i, 2'b00} : 18'd0;
    for (int i = HD - 1; i > 0; i--) begin
      hpx[i] = hpx[i-1]; hins[i] = hins[i-1]; hpic[i] = hpic[i-1];
      hbrd[i] = hbrd[i-1]; hl[i] = hl[i-1]; hc[i] = hc[i-1];
    end
    hpx[0] = px; hins[0] = pic | brd; hpic[0] = pic; hbrd[0] = brd; hl[0] = ln; hc[0] = cl;
    if (nvalid < HD) nvalid++;
    hsync_i = h;  vsync_i = v;
    @(posedge clk);
    if (h) m_h = 0; else if (m_h < 2047) m_h++;
    if (v) m_v = 0; else if (h && m_v < 1023) m_v++;
    if (v) begin s_ph = int'(pos_h_i); s_pv = int'(pos_v_i); end
    @(negedge clk);
    // R5: read request one clock after the counters, with address
    check(mem_rd_en_o == hpic[0], "R5", "mem_rd_en", int'(mem_rd_en_o), int'(hpic[0]));
    if (hpic[0]) begin
      check(int'(mem_rd_line_o) == hl[0], line_dbl_i ? "R6" : "R5", "mem_rd_line",
            int'(mem_rd_line_o), hl[0]);
      check(int'(mem_rd_pix_o) == hc[0], "R5", "mem_rd_pix", int'(mem_rd_pix_o), hc[0]);
    end
    if (nvalid >= HD) begin
      check({pix_y_o, pix_u_o, pix_v_o} == hpx[11],
            hpic[11] ? "R5" : hbrd[11] ? "R4" : "R2", "pixel",
            int'({pix_y_o, pix_u_o, pix_v_o}), int'(hpx[11]));
      d = int'($signed(sel_dly_i));
      check(sel_o == hins[11 + d], "R9", "sel_o", int'(sel_o), int'(hins[11 + d]));
    end
  endtask

  task automatic apply_vec(input vec_t vv);
    pos_h_i = vv.ph;  pos_v_i = vv.pv;
    hdec4_i = vv.hd;  vdec4_i = vv.vd;  std525_i = vv.sd;
    line_dbl_i = vv.db;  pip_on_i = vv.en;
    brd_wh_i = vv.bh;  brd_wv_i = vv.bw;  sel_dly_i = vv.dly;
    brd_y_i = vv.cy;  brd_u_i = vv.cu;  brd_v_i = vv.cv;
  endtask

  initial begin
    apply_vec(VECS[0]);
    for (int i = 0; i < HD; i++) begin
      hpx[i] = '0; hins[i] = 1'b0; hpic[i] = 1'b0; hbrd[i] = 1'b0; hl[i] = 0; hc[i] = 0;
    end
    // R1: reset state
    repeat (3) @(negedge clk);
    check(mem_rd_en_o == 1'b0, "R1", "mem_rd_en in reset", int'(mem_rd_en_o), 0);
    check(sel_o == 1'b0, "R1", "sel_o in reset", int'(sel_o), 0);
    check({pix_y_o, pix_u_o, pix_v_o} == 18'd0, "R1", "pixels in reset",
          int'({pix_y_o, pix_u_o, pix_v_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sel_o == 1'b0 && mem_rd_en_o == 1'b0, "R1", "first cycle after reset",
          int'({sel_o, mem_rd_en_o}), 0);
    check({pix_y_o, pix_u_o, pix_v_o} == 18'd0, "R1", "pixels after reset",
          int'({pix_y_o, pix_u_o, pix_v_o}), 0);

    // Table of field configurations, one field each
    for (int k = 0; k < NVEC; k++) begin
      int nl, ht, nlines;
      vtag = TAGS[k];
      apply_vec(VECS[k]);
      case ({VECS[k].vd, VECS[k].sd})
        2'b00: nl = 88;  2'b01: nl = 76;  2'b10: nl = 66;  default: nl = 57;
      endcase
      ht = VECS[k].db ? 2 * nl : nl;
      nlines = VECS[k].en ? 4 + int'(VECS[k].pv) + ht + int'(VECS[k].bw) + 2 : 30;
      for (int ln = 0; ln < nlines; ln++) begin
        // R7: a position change inside the field must not move the picture
        if (ln == 2 && VECS[k].alt != 10'd0) pos_h_i = VECS[k].alt;
        for (int c = 0; c < LINE; c++) tick(c == 0, c == 0 && ln == 0);
      end
    end
    vtag = "flush";
    for (int i = 0; i < 2 * HD; i++) tick(1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected fewer", WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule